// File: doc/BRIEF.md
# Paced Page-Copy DMA Engine

This block moves a fixed run of 160 bytes from a 256-byte-aligned source page into the sprite attribute region that starts at 0xFE00. A processor starts it by writing one byte to the trigger register. That byte names the source page. From then on the engine runs by itself and asserts `busy` until the last byte has landed.

The engine is clocked by the system clock. A `t_tick` strobe marks each T-cycle. Four T-cycles make one machine cycle, and the engine moves at most one byte per machine cycle. The first machine cycle after a trigger is an idle slot. Each byte is read and written in the same machine cycle, because the read data returns combinationally from the memory. A new trigger write while a transfer is running abandons that transfer and starts over from the new page.

Top module: `pgcopy_dma`

## Requirements
- R1: A write with `reg_wr` high and `reg_addr` equal to 0xFF46 starts a transfer, and `reg_wdata` becomes the source page. A write to any other address changes neither `busy` nor the memory outputs.
- R2: For byte number n (0 to 159), `mem_raddr` equals the page in bits 15:8 and n in bits 7:0.
- R3: For byte n, `mem_waddr` equals 0xFE00 + n, and `mem_wdata` equals the `mem_rdata` of the same cycle.
- R4: Exactly 160 writes follow a trigger, one per byte number in rising order. No `mem_we` pulse occurs while the engine is idle.
- R5: `mem_we` pulses only in a cycle that carries a `t_tick`, at most once per group of four ticks. Cycles without a tick never advance the transfer.
- R6: Counting the `t_tick` pulses after the trigger cycle, the ticks numbered 1 to 4 form the idle slot. Byte n is written on tick 4*(n+2).
- R7: `busy` goes high in the cycle after the trigger write and stays high through the cycle of the 160th write. It is low in the cycle after that write.
- R8: A trigger write during a transfer, including during the idle slot, starts over. It loads the new page, restarts at byte 0, restarts the tick count and applies the idle slot again. No write occurs in the trigger cycle.
- R9: After reset, `busy` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_tick | input | 1 | One pulse per T-cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register write address |
| reg_wdata | input | 8 | Register write data (source page) |
| mem_raddr | output | 16 | Source read address |
| mem_rdata | input | 8 | Source read data, combinational |
| mem_waddr | output | 16 | Destination write address |
| mem_wdata | output | 8 | Destination write data |
| mem_we | output | 1 | Destination write enable |
| busy | output | 1 | Transfer in progress |

## Verification
The bench sweeps source pages spread across the whole 0x00 to 0xFF range, including both ends. This shows up any page bits that are dropped or swapped in the read address. The tick strobe is driven three ways: every cycle, two cycles in three, and one cycle in five. These patterns separate pacing by tick count from pacing by clock count, and they expose an idle slot that is too short or too long. Further runs cover restarts during the idle slot and in mid-copy, and writes to nearby non-trigger addresses while idle and while busy. These show that a restart resets every piece of state and that only the exact trigger address has any effect.

// File: rtl/pgcopy_pkg.sv
package pgcopy_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_COPY  = 2'd2
    } phase_e;

endpackage

// File: rtl/pgcopy_pacer.sv
module pgcopy_pacer #(
    parameter int TICKS_PER_MC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic tick,
    output logic mc_end
);
    localparam int TCNT_W = (TICKS_PER_MC > 1) ? $clog2(TICKS_PER_MC) : 1;
    localparam logic [TCNT_W-1:0] TLAST = TCNT_W'(TICKS_PER_MC - 1);

    logic [TCNT_W-1:0] tcnt_d, tcnt_q;

    always_comb begin
        tcnt_d = tcnt_q;
        mc_end = 1'b0;
        if (clear || !run) begin
            tcnt_d = '0;
        end else if (tick) begin
            if (tcnt_q == TLAST) begin
                tcnt_d = '0;
                mc_end = 1'b1;
            end else begin
                tcnt_d = tcnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tcnt_q <= '0;
        else        tcnt_q <= tcnt_d;
    end

    // R5: a cycle without a tick leaves the phase count untouched
    p_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && !tick) |=> $stable(tcnt_q));

    // R8: a trigger restarts the tick phase
    p_clear_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (tcnt_q == '0));

endmodule

// File: rtl/pgcopy_seq.sv
module pgcopy_seq
    import pgcopy_pkg::*;
#(
    parameter int XFER_LEN    = 160,
    parameter int START_DELAY = 1,
    parameter int PAGE_W      = 8,
    parameter int PROG_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [PAGE_W-1:0] trig_page,
    input  logic              mc_end,
    output logic              busy,
    output logic [PAGE_W-1:0] page,
    output logic [PROG_W-1:0] prog,
    output logic              wr_fire
);
    localparam int DLY_W = (START_DELAY > 1) ? $clog2(START_DELAY) : 1;
    localparam logic [PROG_W-1:0] LAST = PROG_W'(XFER_LEN - 1);
    localparam logic [DLY_W-1:0]  DLY_LOAD = DLY_W'(START_DELAY - 1);

    typedef struct packed {
        phase_e            phase;
        logic [PAGE_W-1:0] page;
        logic [PROG_W-1:0] prog;
        logic [DLY_W-1:0]  dly;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        wr_fire = 1'b0;
        if (trig) begin
            s_d.phase = PH_DELAY;
            s_d.page  = trig_page;
            s_d.prog  = '0;
            s_d.dly   = DLY_LOAD;
        end else begin
            unique case (s_q.phase)
                PH_DELAY: begin
                    if (mc_end) begin
                        if (s_q.dly == '0) s_d.phase = PH_COPY;
                        else               s_d.dly   = s_q.dly - 1'b1;
                    end
                end
                PH_COPY: begin
                    if (mc_end) begin
                        wr_fire = 1'b1;
                        if (s_q.prog == LAST) s_d.phase = PH_IDLE;
                        else                  s_d.prog  = s_q.prog + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.page  <= '0;
            s_q.prog  <= '0;
            s_q.dly   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.phase != PH_IDLE);
    assign page = s_q.page;
    assign prog = s_q.prog;

    // R8: a trigger reloads the page and restarts at byte 0 in the idle slot
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (s_q.prog == '0 && s_q.phase == PH_DELAY && s_q.page == $past(trig_page)));

    // R4: progress never passes the last byte number while active
    p_prog_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (s_q.prog <= LAST));

    // R4: the write of the last byte ends the transfer
    p_last_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && s_q.prog == LAST) |=> !busy);

    // R5: without a machine-cycle end or trigger, progress and phase hold
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !mc_end) |=> ($stable(s_q.prog) && $stable(s_q.phase)));

    // R6: nothing is written during the idle slot
    p_delay_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_DELAY) |-> !wr_fire);

endmodule

// File: rtl/pgcopy_addr.sv
module pgcopy_addr #(
    parameter int                ADDR_W   = 16,
    parameter int                PAGE_W   = 8,
    parameter int                PROG_W   = 8,
    parameter logic [ADDR_W-1:0] DST_BASE = 16'hFE00
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [PROG_W-1:0] prog,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    localparam int OFS_W = ADDR_W - PAGE_W;

    always_comb begin
        src_addr = {page, OFS_W'(prog)};
        dst_addr = DST_BASE + ADDR_W'(prog);
    end

endmodule

// File: rtl/pgcopy_dma.sv
module pgcopy_dma #(
    parameter int           ADDR_W       = 16,
    parameter int           DATA_W       = 8,
    parameter int           XFER_LEN     = 160,
    parameter int           TICKS_PER_MC = 4,
    parameter int           START_DELAY  = 1,
    parameter logic [15:0]  TRIG_ADDR    = 16'hFF46,
    parameter logic [15:0]  DST_BASE     = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              t_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              busy
);
    localparam int PAGE_W = DATA_W;
    localparam int PROG_W = $clog2(XFER_LEN);

    logic              trig;
    logic              mc_end;
    logic [PAGE_W-1:0] page;
    logic [PROG_W-1:0] prog;

    assign trig = reg_wr && (reg_addr == ADDR_W'(TRIG_ADDR));

    pgcopy_pacer #(.TICKS_PER_MC(TICKS_PER_MC)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .clear  (trig),
        .tick   (t_tick),
        .mc_end (mc_end)
    );

    pgcopy_seq #(
        .XFER_LEN    (XFER_LEN),
        .START_DELAY (START_DELAY),
        .PAGE_W      (PAGE_W),
        .PROG_W      (PROG_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .trig_page (reg_wdata),
        .mc_end    (mc_end),
        .busy      (busy),
        .page      (page),
        .prog      (prog),
        .wr_fire   (mem_we)
    );

    pgcopy_addr #(
        .ADDR_W   (ADDR_W),
        .PAGE_W   (PAGE_W),
        .PROG_W   (PROG_W),
        .DST_BASE (ADDR_W'(DST_BASE))
    ) u_addr (
        .page     (page),
        .prog     (prog),
        .src_addr (mem_raddr),
        .dst_addr (mem_waddr)
    );

    assign mem_wdata = mem_rdata;

    // R4: writes happen only while a transfer is in progress
    p_we_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R3: every write lands inside the destination window
    p_dst_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_waddr >= ADDR_W'(DST_BASE) &&
                    mem_waddr <  ADDR_W'(DST_BASE) + ADDR_W'(XFER_LEN)));

    // R5: a write needs a tick in the same cycle
    p_we_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> t_tick);

    // R8: no write in a trigger cycle
    p_trig_no_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> !mem_we);

endmodule

// File: tb/sim_pgcopy_dma.sv
module sim_pgcopy_dma;
    localparam logic [15:0] TRIG = 16'hFF46;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        t_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] mem_raddr, mem_waddr;
    logic [7:0]  mem_rdata, mem_wdata;
    logic        mem_we, busy;

    always #4 clk = ~clk;

    pgcopy_dma u0 (
        .clk(clk), .rst_n(rst_n), .t_tick(t_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .busy(busy)
    );

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        return a[15:8] ^ {a[6:0], a[7]} ^ 8'hA5;
    endfunction

    assign mem_rdata = src_byte(mem_raddr);

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    int  tick_mode = 0;
    int  cyc = 0;

    // bench model of the transfer
    bit        b_act = 0;
    logic [7:0] b_page = '0;
    int        b_n = 0;
    int        b_tk = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // tick driver: changes one unit after the rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        case (tick_mode)
            0:       t_tick = 1'b1;
            1:       t_tick = (cyc % 3) != 2;
            default: t_tick = (cyc % 5) == 0;
        endcase
    end

    // monitor, samples at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == b_act, "R7 busy level", busy, b_act);
            if (reg_wr && reg_addr == TRIG) begin
                chk(!mem_we, "R8 write in trigger cycle", mem_we, 0);
                b_act  = 1;
                b_page = reg_wdata;
                b_n    = 0;
                b_tk   = 0;
            end else begin
                bit exp_we;
                if (t_tick && b_act) b_tk++;
                exp_we = b_act && t_tick && (b_tk >= 8) && (b_tk % 4 == 0);
                chk(mem_we == exp_we, "R5/R6 write slot", mem_we, exp_we);
                if (mem_we && exp_we) begin
                    logic [15:0] ea;
                    ea = {b_page, 8'(b_n)};
                    chk(mem_raddr == ea, "R2 source address", mem_raddr, ea);
                    chk(mem_waddr == 16'hFE00 + 16'(b_n), "R3 dest address",
                        mem_waddr, 16'hFE00 + 16'(b_n));
                    chk(mem_wdata == src_byte(ea), "R3 write data", mem_wdata, src_byte(ea));
                    b_n++;
                    if (b_n == 160) b_act = 0;
                end
            end
        end
    end

    task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int guard = 0;
        @(negedge clk);
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(!busy, {tag, " transfer ends"}, busy, 0);
        chk(b_n == 160, {tag, " byte count R4"}, b_n, 160);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R9 busy after reset", busy, 0);
        chk(!mem_we, "R9 write enable after reset", mem_we, 0);

        // R1: non-trigger address while idle
        reg_write(16'hFF47, 8'h12);
        reg_write(16'hFF45, 8'h34);
        repeat (20) @(negedge clk);
        chk(!busy, "R1 other address ignored", busy, 0);

        // page sweep with a tick every cycle
        for (int p = 0; p < 256; p += 17) begin
            reg_write(TRIG, 8'(p));
            wait_idle("R1 page sweep");
        end
        reg_write(TRIG, 8'hFF);
        wait_idle("R2 top page");

        // R5: sparse tick patterns
        tick_mode = 1;
        reg_write(TRIG, 8'h80);
        wait_idle("R5 two-in-three ticks");
        tick_mode = 2;
        reg_write(TRIG, 8'h7F);
        wait_idle("R5 one-in-five ticks");
        tick_mode = 0;

        // R8: restart mid-copy
        reg_write(TRIG, 8'h11);
        while (b_n < 50) @(negedge clk);
        reg_write(TRIG, 8'hC3);
        chk(b_page == 8'hC3, "R8 new page taken", b_page, 8'hC3);
        wait_idle("R8 mid-copy restart");

        // R8: restart inside the idle slot
        reg_write(TRIG, 8'h22);
        reg_write(TRIG, 8'h5D);
        wait_idle("R8 idle-slot restart");

        // R1: non-trigger write while busy does not disturb the copy
        reg_write(TRIG, 8'h3C);
        while (b_n < 20) @(negedge clk);
        reg_write(16'hFF47, 8'h99);
        wait_idle("R1 other address while busy");

        finish_run();
    end
endmodule